// File: doc/BRIEF.md
# MDIO Management Controller

This block is a serial management master for PHY devices. Software programs a control word, which sets the MDC clock divisor, enables a preamble and selects an extended addressing mode. It then writes a frame word that carries the operation, the port and register addresses, a turnaround code and the write data. The block shifts the frame out on MDC/MDIO. On a read it releases the data line and captures the 16 returned bits. It then raises a completion flag that software polls.

In extended mode the access frame does not carry the device field. Instead, the block first sends a separate write frame that selects the device block at a fixed port and register. It then sends the real access addressed to that fixed port. After each transaction, software rewrites the control word. Writing a zero control word while a frame is running cancels the frame at once.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is running, MDC is low and the MDIO output enable is low. Both words read as zero after reset.
- R2: A frame starts only if the frame word (bus_addr = 1) is written while idle, bit 30 is 1, and exactly one of bit 29 (read) or bit 28 (write) is set. Any other frame-word write sends nothing and leaves the completion flag clear.
- R3: The wire frame is sent MSB first in this order: start code 0,1; opcode (read = 1,0, write = 0,1); a 5-bit port address taken from frame bits 26:22; a 5-bit register address formed as {0, frame bits 21:18}; two turnaround bits; 16 data bits. A write drives turnaround as {frame bit 17, 0} and data from frame bits 15:0.
- R4: When control bit 7 is set, 32 one bits are driven before the start code of every frame.
- R5: The MDC half period is (D + 1) system clocks, where D is control bits 6:0. MDIO and its enable change only when MDC falls. The input is sampled as MDC rises.
- R6: On a read, the output enable is released for both turnaround bits and the 16 data bits. After completion, a frame-word read returns the original frame bits 31:16 in the upper half and the 16 captured bits in bits 15:0. After a write, bits 15:0 read back as the write data.
- R7: Control bit 8 (read-only) is set when the last frame ends. It is cleared by any control-word write and by the start of a new frame. It is never set while a frame is running.
- R8: When control bit 9 is set, a write frame is sent first to port 0, register 31, with data {11 zeros, frame bits 26:22}. The access frame follows at once, addressed to port 0.
- R9: A frame-word write while a frame is running is ignored. The stored frame bits and the frame on the wire are unchanged.
- R10: A control-word write of zero while a frame is running ends it on the next clock. MDC goes low, the enable is released, and the completion flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | 1 | Register select: 0 = control word, 1 = frame word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The checker watches several rules on every cycle: the quiet idle line, the rule that the data line and its enable only move on a falling MDC, the exclusion between running and completed, the frozen frame word under a busy write, and the one-clock cancel. The bench's scenarios show the rest. A monitor on MDC recovers the bit stream and compares it with a frame built from the requirements, including the preamble and the two-frame extended sequence. It also responds on mdio_i so that the captured read data can be compared. Its timing check measures the MDC period for several divisors.

// File: rtl/mdio_pkg.sv
// mdio_pkg: shared constants, the serial frame container type and the
// frame builder used by the management master.
// Assumes clause-22 style frames of 32 bits, optionally led by 32 ones.
package mdio_pkg;

    localparam int BODY_BITS = 32;
    localparam int PRE_BITS  = 32;
    localparam int VEC_W     = BODY_BITS + PRE_BITS;
    localparam int LEN_W     = $clog2(VEC_W + 1);
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;

    // Control word fields
    localparam int CTL_PRE_BIT  = 7;
    localparam int CTL_DONE_BIT = 8;
    localparam int CTL_EXT_BIT  = 9;
    localparam int CTL_DIV_MAX  = 7;

    // Frame word fields
    localparam int FRM_GO_BIT = 30;
    localparam int FRM_RD_BIT = 29;
    localparam int FRM_WR_BIT = 28;
    localparam int FRM_TA_BIT = 17;
    localparam int FRM_DEV_LO = 22;
    localparam int FRM_REG_LO = 18;

    // Serial image: bits and enables left-justified, sent from the MSB
    typedef struct packed {
        logic [VEC_W-1:0] dat;
        logic [VEC_W-1:0] oe;
        logic [LEN_W-1:0] len;
    } mdio_frm_t;

    // Builds the serial image of one management frame
    function automatic mdio_frm_t build_frame(
        input logic              pre,
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic              ta,
        input logic [DATA_W-1:0] wd
    );
        mdio_frm_t               f;
        logic [BODY_BITS-1:0]    body;
        logic [BODY_BITS-1:0]    body_oe;
        body    = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                   (rd ? 2'b11 : {ta, 1'b0}), (rd ? 16'hFFFF : wd)};
        body_oe = rd ? {14'h3FFF, 18'h00000} : 32'hFFFF_FFFF;
        if (pre) begin
            f.dat = {32'hFFFF_FFFF, body};
            f.oe  = {32'hFFFF_FFFF, body_oe};
            f.len = LEN_W'(VEC_W);
        end else begin
            f.dat = {body, 32'h0};
            f.oe  = {body_oe, 32'h0};
            f.len = LEN_W'(BODY_BITS);
        end
        return f;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// mdio_clkgen: divides the system clock into MDC while a frame runs.
// Half period is (div + 1) clocks. rise/fall pulse in the clock before MDC
// toggles. MDC is held low and the count cleared whenever the sequencer is
// idle now or becomes idle on this edge.
module mdio_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_now,
    input  logic             run_next,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             edge_due;

    // Half period elapsed
    assign edge_due = (cnt_q == div);
    assign rise     = run_now && edge_due && !mdc;
    assign fall     = run_now && edge_due && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_now || !run_next) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (edge_due) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_seq.sv
// mdio_seq: shifts one or two prepared frame images onto MDIO.
// Advances one bit per falling MDC and samples MDIO into a 16-bit shift
// register on each rising MDC while the output enable is released.
// Assumes start only while idle and abort only while busy.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  mdio_frm_t         first_frm,
    input  mdio_frm_t         second_frm,
    input  logic              has_second,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              busy_next,
    output logic              done_stb,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] cap
);

    logic             busy_q;
    logic             pend_q;
    logic [VEC_W-1:0] dat_q;
    logic [VEC_W-1:0] oe_q;
    logic [LEN_W-1:0] left_q;
    mdio_frm_t        next_q;
    logic [DATA_W-1:0] cap_q;
    logic             last_bit;

    // Last bit of the current frame ends on this falling MDC
    assign last_bit  = busy_q && fall && (left_q == LEN_W'(1));
    assign done_stb  = last_bit && !pend_q && !abort;
    assign busy_next = start ? 1'b1 : ((abort || done_stb) ? 1'b0 : busy_q);
    assign busy      = busy_q;
    assign mdio_o    = busy_q ? dat_q[VEC_W-1] : 1'b1;
    assign mdio_oe   = busy_q && oe_q[VEC_W-1];
    assign cap       = cap_q;

    // Frame loading, bit advance and chaining of the second frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            dat_q  <= '0;
            oe_q   <= '0;
            left_q <= '0;
            next_q <= '0;
        end else begin
            busy_q <= busy_next;
            if (start) begin
                dat_q  <= first_frm.dat;
                oe_q   <= first_frm.oe;
                left_q <= first_frm.len;
                next_q <= second_frm;
                pend_q <= has_second;
            end else if (abort) begin
                pend_q <= 1'b0;
            end else if (last_bit && pend_q) begin
                dat_q  <= next_q.dat;
                oe_q   <= next_q.oe;
                left_q <= next_q.len;
                pend_q <= 1'b0;
            end else if (busy_q && fall) begin
                dat_q  <= {dat_q[VEC_W-2:0], 1'b0};
                oe_q   <= {oe_q[VEC_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end
        end
    end

    // Capture of input bits while the line is released
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cap_q <= '0;
        end else if (busy_q && rise && !oe_q[VEC_W-1]) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        end
    end

endmodule

// File: rtl/mdio_regs.sv
// mdio_regs: control and frame words behind a one-bit register select.
// Decodes the start and cancel commands, keeps the completion flag and
// merges captured read data into the frame word read-back.
// Assumes DIV_W is at most 7 (divisor occupies control bits 6:0).
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              busy,
    input  logic              done_stb,
    input  logic [DATA_W-1:0] cap,
    output logic [31:0]       bus_rdata,
    output logic [DIV_W-1:0]  div,
    output logic              pre,
    output logic              ext,
    output logic              done,
    output logic [15:0]       frame_hi,
    output logic              start,
    output logic              abort
);

    logic [DIV_W-1:0]   div_q;
    logic               pre_q;
    logic               ext_q;
    logic               done_q;
    logic               rd_q;
    logic [15:0]        hi_q;
    logic [DATA_W-1:0]  low_q;
    logic               ctl_wr;
    logic               frm_wr;
    logic               op_ok;
    logic [CTL_DIV_MAX-1:0] div_rd;

    assign ctl_wr = bus_wr && !bus_addr;
    assign frm_wr = bus_wr && bus_addr && !busy;
    assign op_ok  = bus_wdata[FRM_RD_BIT] ^ bus_wdata[FRM_WR_BIT];
    assign start  = frm_wr && bus_wdata[FRM_GO_BIT] && op_ok;
    assign abort  = ctl_wr && busy && (bus_wdata == 32'h0);
    assign div_rd = CTL_DIV_MAX'(div_q);

    // Control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (ctl_wr) begin
            div_q <= bus_wdata[DIV_W-1:0];
            pre_q <= bus_wdata[CTL_PRE_BIT];
            ext_q <= bus_wdata[CTL_EXT_BIT];
        end
    end

    // Completion flag: set at frame end, cleared by control write or start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_stb) begin
            done_q <= 1'b1;
        end else if (ctl_wr || start) begin
            done_q <= 1'b0;
        end
    end

    // Frame word storage and read-data merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            low_q <= '0;
            rd_q  <= 1'b0;
        end else if (frm_wr) begin
            hi_q  <= bus_wdata[31:16];
            low_q <= bus_wdata[DATA_W-1:0];
            rd_q  <= bus_wdata[FRM_RD_BIT];
        end else if (done_stb && rd_q) begin
            low_q <= cap;
        end
    end

    // Read mux
    always_comb begin
        if (bus_addr) begin
            bus_rdata = {hi_q, low_q};
        end else begin
            bus_rdata = {22'h0, ext_q, done_q, pre_q, div_rd};
        end
    end

    assign div      = div_q;
    assign pre      = pre_q;
    assign ext      = ext_q;
    assign done     = done_q;
    assign frame_hi = hi_q;

endmodule

// File: rtl/mdio_master.sv
// mdio_master: register-mapped MDIO management master (top level).
// Builds the frame images from the frame word as it is written, latches
// the divisor for the running transfer and wires registers, sequencer and
// clock generator together.
// Assumes a single master on the management bus.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int          DIV_W    = 7,
    parameter logic [4:0]  EXT_PORT = 5'd0,
    parameter logic [4:0]  BLK_REG  = 5'd31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [DIV_W-1:0]  div;
    logic [DIV_W-1:0]  run_div_q;
    logic              pre;
    logic              ext;
    logic              done_q;
    logic [15:0]       frame_q;
    logic              start;
    logic              abort;
    logic              busy;
    logic              busy_next;
    logic              done_stb;
    logic              rise_stb;
    logic              fall_stb;
    logic [DATA_W-1:0] cap;
    logic [ADDR_W-1:0] dev;
    logic [ADDR_W-1:0] rg;
    logic [ADDR_W-1:0] acc_phy;
    mdio_frm_t         acc_frm;
    mdio_frm_t         blk_frm;
    mdio_frm_t         first_frm;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .busy     (busy),
        .done_stb (done_stb),
        .cap      (cap),
        .bus_rdata(bus_rdata),
        .div      (div),
        .pre      (pre),
        .ext      (ext),
        .done     (done_q),
        .frame_hi (frame_q),
        .start    (start),
        .abort    (abort)
    );

    // Frame images prepared from the incoming frame word
    always_comb begin
        dev       = bus_wdata[FRM_DEV_LO +: ADDR_W];
        rg        = {1'b0, bus_wdata[FRM_REG_LO +: ADDR_W-1]};
        acc_phy   = ext ? EXT_PORT : dev;
        acc_frm   = build_frame(pre, bus_wdata[FRM_RD_BIT], acc_phy, rg,
                                bus_wdata[FRM_TA_BIT], bus_wdata[DATA_W-1:0]);
        blk_frm   = build_frame(pre, 1'b0, EXT_PORT, BLK_REG,
                                bus_wdata[FRM_TA_BIT], {11'h0, dev});
        first_frm = ext ? blk_frm : acc_frm;
    end

    // Divisor held constant for the whole transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_div_q <= '0;
        end else if (start) begin
            run_div_q <= div;
        end
    end

    mdio_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .first_frm (first_frm),
        .second_frm(acc_frm),
        .has_second(ext),
        .rise      (rise_stb),
        .fall      (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .busy_next (busy_next),
        .done_stb  (done_stb),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cap       (cap)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_now (busy),
        .run_next(busy_next),
        .div     (run_div_q),
        .mdc     (mdc),
        .rise    (rise_stb),
        .fall    (fall_stb)
    );

endmodule

// File: rtl/mdio_master_chk.sv
// mdio_master_chk: cycle-level rules of the management master, bound to
// every instance of mdio_master.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        fall,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [31:0] bus_wdata,
    input logic [15:0] frame_q
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R5
    mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(fall)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr) |=> $stable(frame_q));

    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && !bus_addr && (bus_wdata == 32'h0)) |=> (!busy && !done && !mdc));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done_q),
    .fall     (fall_stb),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .frame_q  (frame_q)
);

// File: tb/tb_mdio_master.sv
// tb_mdio_master: vector table of transfers walked by one loop, then
// directed tests for reset, rejected starts, busy writes and cancel.
module tb_mdio_master;

    localparam int CLK_NS = 20;
    localparam int NVEC   = 6;
    localparam int MAXB   = 160;

    // {control[31:0], frame[31:0], response[15:0]}
    // frame = {0, go, rd, wr, 0, dev[4:0], reg[3:0], ta, 0, data[15:0]}
    localparam logic [79:0] VECS [NVEC] = '{
        {32'h0000_0002, 1'b0,1'b1,1'b0,1'b1,1'b0, 5'h05, 4'h3, 1'b1, 1'b0, 16'hA5C3, 16'h0000},
        {32'h0000_0000, 1'b0,1'b1,1'b1,1'b0,1'b0, 5'h1F, 4'hF, 1'b0, 1'b0, 16'h0000, 16'h1234},
        {32'h0000_0081, 1'b0,1'b1,1'b0,1'b1,1'b0, 5'h10, 4'h8, 1'b0, 1'b0, 16'hFFFF, 16'h0000},
        {32'h0000_0083, 1'b0,1'b1,1'b1,1'b0,1'b0, 5'h0A, 4'h1, 1'b1, 1'b0, 16'h0000, 16'hBEEF},
        {32'h0000_0201, 1'b0,1'b1,1'b0,1'b1,1'b0, 5'h1D, 4'h1, 1'b1, 1'b0, 16'h4000, 16'h0000},
        {32'h0000_0282, 1'b0,1'b1,1'b1,1'b0,1'b0, 5'h1F, 4'h2, 1'b1, 1'b0, 16'h0000, 16'h8128}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int mon_idx = 0;
    int base = 0;
    int n_exp = 0;
    logic exp_v  [MAXB];
    logic exp_oe [MAXB];
    logic drv_in [MAXB];
    logic got_v  [MAXB];
    logic got_oe [MAXB];
    int   rise_t [MAXB];
    int   rel;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // Responder: value for bit k is presented before the k-th rising MDC
    assign rel    = mon_idx - base;
    assign mdio_i = (rel >= 0 && rel < MAXB) ? drv_in[rel] : 1'b1;

    // Monitor: record line state on each rising MDC
    always @(posedge mdc) begin : mon
        int k;
        k = mon_idx - base;
        if (k >= 0 && k < MAXB) begin
            got_v[k]  = mdio_o;
            got_oe[k] = mdio_oe;
            rise_t[k] = cyc;
        end
        mon_idx++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] r;
        ok = 1'b0;
        for (int i = 0; i < 20000 && !ok; i++) begin
            bus_read(1'b0, r);
            ok = r[8];
        end
    endtask

    task automatic push(input logic v, input logic oe, input logic din);
        exp_v[n_exp] = v; exp_oe[n_exp] = oe; drv_in[n_exp] = din;
        n_exp++;
    endtask

    task automatic add_frame(input logic pre, input logic rd, input logic [4:0] phy,
                             input logic [4:0] rg, input logic ta,
                             input logic [15:0] dat, input logic [15:0] resp);
        if (pre) for (int i = 0; i < 32; i++) push(1'b1, 1'b1, 1'b1);
        push(1'b0, 1'b1, 1'b1);
        push(1'b1, 1'b1, 1'b1);
        push(rd, 1'b1, 1'b1);
        push(!rd, 1'b1, 1'b1);
        for (int i = 4; i >= 0; i--) push(phy[i], 1'b1, 1'b1);
        for (int i = 4; i >= 0; i--) push(rg[i], 1'b1, 1'b1);
        if (rd) begin
            push(1'b0, 1'b0, 1'b1);
            push(1'b0, 1'b0, 1'b0);
            for (int i = 15; i >= 0; i--) push(1'b0, 1'b0, resp[i]);
        end else begin
            push(ta, 1'b1, 1'b1);
            push(1'b0, 1'b1, 1'b1);
            for (int i = 15; i >= 0; i--) push(dat[i], 1'b1, 1'b1);
        end
    endtask

    // Expected wire image of a whole transfer from control and frame words
    task automatic plan_xfer(input logic [31:0] ctl, input logic [31:0] fr, input logic [15:0] resp);
        n_exp = 0;
        for (int i = 0; i < MAXB; i++) drv_in[i] = 1'b1;
        if (ctl[9]) begin
            add_frame(ctl[7], 1'b0, 5'd0, 5'd31, fr[17], {11'h0, fr[26:22]}, 16'h0);
            add_frame(ctl[7], fr[29], 5'd0, {1'b0, fr[21:18]}, fr[17], fr[15:0], resp);
        end else begin
            add_frame(ctl[7], fr[29], fr[26:22], {1'b0, fr[21:18]}, fr[17], fr[15:0], resp);
        end
        base = mon_idx;
    endtask

    function automatic int wire_errors();
        int e;
        e = 0;
        for (int i = 0; i < n_exp; i++) begin
            if (got_oe[i] !== exp_oe[i]) e++;
            else if (exp_oe[i] && (got_v[i] !== exp_v[i])) e++;
        end
        return e;
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R6";
            2: return "R4";
            3: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Watchdog: a hung run is one failed check
    initial begin
        #(CLK_NS * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R7 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] ctl;
        logic [31:0] fr;
        logic [15:0] resp;
        logic [31:0] exp_rb;
        bit ok;
        int snap;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(1'b0, r);
        chk(r == 32'h0, "R1 control after reset", r, 32'h0);
        bus_read(1'b1, r);
        chk(r == 32'h0, "R1 frame after reset", r, 32'h0);
        chk(!mdc && !mdio_oe, "R1 line quiet after reset", {30'h0, mdc, mdio_oe}, 32'h0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            ctl  = VECS[v][79:48];
            fr   = VECS[v][47:16];
            resp = VECS[v][15:0];
            plan_xfer(ctl, fr, resp);
            bus_write(1'b0, ctl);
            bus_write(1'b1, fr);
            wait_done(ok);
            chk(ok, "R7 done flag set", {31'h0, ok}, 32'h1);
            chk(mon_idx - base == n_exp, {vec_tag(v), " bit count"}, mon_idx - base, n_exp);
            chk(wire_errors() == 0, {vec_tag(v), " wire image"}, wire_errors(), 32'h0);
            chk(rise_t[1] - rise_t[0] == 2 * (int'(ctl[6:0]) + 1), "R5 MDC period",
                rise_t[1] - rise_t[0], 2 * (int'(ctl[6:0]) + 1));
            exp_rb = fr[29] ? {fr[31:16], resp} : fr;
            bus_read(1'b1, r);
            chk(r == exp_rb, "R6 frame read-back", r, exp_rb);
            chk(!mdc && !mdio_oe, "R1 line quiet after frame", {30'h0, mdc, mdio_oe}, 32'h0);
            bus_write(1'b0, ctl);
            bus_read(1'b0, r);
            chk(r[8] == 1'b0, "R7 control write clears done", r, ctl);
        end

        // R2: start bit clear, and both opcodes set
        base = mon_idx;
        bus_write(1'b0, 32'h1);
        bus_write(1'b1, 32'h2000_1234);
        repeat (40) @(negedge clk);
        chk(mon_idx == base && !mdc, "R2 no frame without start bit", mon_idx - base, 32'h0);
        bus_write(1'b1, 32'h7000_5678);
        repeat (40) @(negedge clk);
        chk(mon_idx == base, "R2 no frame with both opcodes", mon_idx - base, 32'h0);
        bus_read(1'b0, r);
        chk(r[8] == 1'b0, "R2 done stays clear", r, 32'h1);

        // R9: frame write while busy is ignored
        ctl = 32'h3;
        fr  = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h12, 4'h6, 1'b1, 1'b0, 16'h3C5A};
        plan_xfer(ctl, fr, 16'h0);
        bus_write(1'b0, ctl);
        bus_write(1'b1, fr);
        repeat (20) @(negedge clk);
        bus_write(1'b1, 32'h6FC0_0000);
        bus_read(1'b1, r);
        chk(r[31:16] == fr[31:16], "R9 busy write leaves frame word", r, fr);
        wait_done(ok);
        chk(ok && wire_errors() == 0 && (mon_idx - base == n_exp), "R9 wire unchanged by busy write",
            wire_errors(), 32'h0);
        bus_read(1'b1, r);
        chk(r == fr, "R9 read-back after ignored write", r, fr);

        // R10: cancel with a zero control write
        ctl = 32'h83;
        fr  = {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'h01, 4'h2, 1'b0, 1'b0, 16'h0};
        plan_xfer(ctl, fr, 16'hAAAA);
        bus_write(1'b0, ctl);
        bus_write(1'b1, fr);
        repeat (100) @(negedge clk);
        bus_write(1'b0, 32'h0);
        chk(!mdc && !mdio_oe, "R10 line released after cancel", {30'h0, mdc, mdio_oe}, 32'h0);
        snap = mon_idx;
        repeat (300) @(negedge clk);
        chk(mon_idx == snap, "R10 no MDC after cancel", mon_idx - snap, 32'h0);
        bus_read(1'b0, r);
        chk(r == 32'h0, "R10 done stays clear after cancel", r, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule